// File: doc/BRIEF.md
# Multi-Block Write Sequencer

The sequencer runs a host-side multi-block write to a memory card over a single serial data line. Software sets the block length in bytes (equal to the length the card was given with CMD16), the number of blocks, whether the stop command goes out on its own, and whether the payload arrives as a stream. A start pulse then runs the whole operation with no further help. The sequencer waits until the card reports that it can accept data and requests CMD25 from the command-line unit. It then sends each block framed with a CRC, reads the card's CRC status token, and holds off the next block for as long as the card keeps the line low. Once the block count runs out, or when a block fails, it requests CMD12.

Payload bytes come in over a valid/ready handshake. Each outgoing bit is marked by a strobe, which the surrounding logic uses to clock the card. At the end the block raises a level interrupt that stays high until the next accepted start. Three error flags come with it: a token that was not "accepted", a busy period that ran too long, and an error reported on the response to the automatic stop command. The buffer-write-ready interrupt is suppressed whenever streaming mode is selected.

Top module: `blkwr_seq`

## Requirements
- R1: After reset the block is idle: cmdReq, datOe, datStrobe, wrReady, doneIrq and all error flags are 0.
- R2: A start pulse with a nonzero block count is accepted only in idle. CMD25 (cmdIdx 25) is requested only while cardReady is 1, and no command is requested while it is 0. A start with block count 0 is ignored: no command, no data, and doneIrq keeps its level.
- R3: Each block goes out on datOut, one bit per datStrobe cycle. The order is: a start bit 0, then cfgBlkSize bytes with each byte MSB first, then a CRC-16 (polynomial 0x1021, initial value 0, MSB first) taken over the data bits, then an end bit 1.
- R4: A payload byte is taken only in a cycle where both wrValid and wrReady are 1. Gaps in wrValid stall the block without losing, repeating or reordering any byte.
- R5: After the end bit the line is released. The sequencer waits for a 0 start bit on datIn and then reads three status bits, MSB first. The value 010 accepts the block. Any other value sets errDataCrc and ends the transfer with no further blocks.
- R6: While datIn is low after an accepted token, no new block starts. If datIn stays low for BUSY_LIMIT cycles, errBusyTo is set and the transfer ends.
- R7: blkRemain loads the block count at start and drops by one for each accepted block only. The transfer ends after the last block.
- R8: With cfgAutoStop = 1, CMD12 (cmdIdx 12) is requested once after the transfer ends, whether it ended normally or on an error. With cfgAutoStop = 0 no CMD12 is requested.
- R9: If cmdRespErr is 1 together with cmdDone on the CMD12 response, errStop is set.
- R10: doneIrq rises only after the whole operation has finished, including the CMD12 response when auto-stop is enabled. It stays high until the next accepted start, which also clears the error flags.
- R11: bufWrRdyIrq follows wrReady when cfgStreamMode = 0 and stays 0 when cfgStreamMode = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for a transfer |
| cfgBlkSize | input | SZ_W | Block length in bytes (1 or more) |
| cfgBlkCnt | input | CNT_W | Number of blocks to write |
| cfgAutoStop | input | 1 | Send CMD12 automatically at the end |
| cfgStreamMode | input | 1 | Streaming mode; masks bufWrRdyIrq |
| cardReady | input | 1 | Card status reports ready for data |
| cmdReq | output | 1 | One-cycle command request |
| cmdIdx | output | 6 | Index of the requested command |
| cmdDone | input | 1 | Command response received |
| cmdRespErr | input | 1 | Error seen on that response |
| wrData | input | 8 | Payload byte |
| wrValid | input | 1 | Payload byte valid |
| wrReady | output | 1 | Sequencer takes a byte |
| datOut | output | 1 | Bit driven on the data line |
| datOe | output | 1 | Data line driven by the host |
| datStrobe | output | 1 | datOut carries a new bit this cycle |
| datIn | input | 1 | Data line level from the card |
| blkRemain | output | CNT_W | Blocks not yet accepted |
| doneIrq | output | 1 | Transfer-complete interrupt (level) |
| errDataCrc | output | 1 | Token other than accepted |
| errBusyTo | output | 1 | Busy period timed out |
| errStop | output | 1 | Error on automatic stop response |
| bufWrRdyIrq | output | 1 | Buffer-write-ready interrupt |

## Verification
The main write path is run with a one-block transfer, a three-block transfer with a gappy payload stream and a longer busy period, and a two-block transfer without auto-stop. These runs separate framing and CRC faults from faults in handshake stalls and in stop-command issue. A card model checks every received frame against its own CRC and the expected byte sequence, so a single-bit slip shows up. Further runs give a rejected token in the middle of a multi-block transfer, a busy period longer than the limit, and an error on the stop response, and each of these must raise only its own flag. A delayed ready, a zero block count and streaming mode show that nothing leaks out early or in the wrong mode.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

  localparam logic [5:0] CMD_WRITE_MULTI = 6'd25;
  localparam logic [5:0] CMD_STOP        = 6'd12;
  localparam logic [2:0] TOKEN_ACCEPT    = 3'b010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_RDY, ST_CMD_WAIT, ST_SND_START, ST_SND_DATA,
    ST_SND_CRC, ST_SND_END, ST_TOKEN, ST_TOK_BITS, ST_TOK_END,
    ST_BUSY, ST_STOP_REQ, ST_STOP_WAIT, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic ldCfg;
    logic clrBlk;
    logic ldByte;
    logic shData;
    logic shCrc;
    logic tokClr;
    logic tokShift;
    logic busyClr;
    logic busyInc;
    logic blkDec;
  } dpCtl_t;

endpackage

// File: rtl/blkwr_dp.sv
module blkwr_dp
  import blkwr_pkg::*;
#(
  parameter int SZ_W       = 10,
  parameter int CNT_W      = 16,
  parameter int BUSY_LIMIT = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [SZ_W-1:0]  cfgBlkSize,
  input  logic [CNT_W-1:0] cfgBlkCnt,
  input  logic [7:0]       wrData,
  input  logic             datIn,
  output logic             bitEmpty,
  output logic             shMsb,
  output logic             crcMsb,
  output logic             dataLast,
  output logic             crcLast,
  output logic             tokLast,
  output logic             tokOk,
  output logic             busyTo,
  output logic             blkLast,
  output logic [CNT_W-1:0] blkRemain
);

  localparam int BUSY_W = $clog2(BUSY_LIMIT + 1);
  localparam logic [15:0] CRC_POLY = 16'h1021;

  logic [7:0]        shReg;
  logic [3:0]        bitCnt;
  logic [SZ_W-1:0]   byteCnt;
  logic [15:0]       crcReg;
  logic [3:0]        crcCnt;
  logic [2:0]        tokSh;
  logic [1:0]        tokCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              crcFb;

  assign crcFb    = shReg[7] ^ crcReg[15];
  assign bitEmpty = (bitCnt == 4'd0);
  assign shMsb    = shReg[7];
  assign crcMsb   = crcReg[15];
  assign dataLast = (bitCnt == 4'd1) && (byteCnt == '0);
  assign crcLast  = (crcCnt == 4'd15);
  assign tokLast  = (tokCnt == 2'd2);
  assign tokOk    = (tokSh == TOKEN_ACCEPT);
  assign busyTo   = (busyCnt == BUSY_W'(BUSY_LIMIT - 1));
  assign blkLast  = (blkRemain == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      bitCnt  <= '0;
      byteCnt <= '0;
      crcReg  <= '0;
      crcCnt  <= '0;
    end else if (ctl.clrBlk) begin
      bitCnt  <= '0;
      byteCnt <= cfgBlkSize;
      crcReg  <= '0;
      crcCnt  <= '0;
    end else if (ctl.ldByte) begin
      shReg   <= wrData;
      bitCnt  <= 4'd8;
      byteCnt <= byteCnt - 1'b1;
    end else if (ctl.shData) begin
      shReg   <= {shReg[6:0], 1'b0};
      bitCnt  <= bitCnt - 1'b1;
      crcReg  <= {crcReg[14:0], 1'b0} ^ (crcFb ? CRC_POLY : 16'h0);
    end else if (ctl.shCrc) begin
      crcReg  <= {crcReg[14:0], 1'b0};
      crcCnt  <= crcCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokSh  <= '0;
      tokCnt <= '0;
    end else if (ctl.tokClr) begin
      tokSh  <= '0;
      tokCnt <= '0;
    end else if (ctl.tokShift) begin
      tokSh  <= {tokSh[1:0], datIn};
      tokCnt <= tokCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busyCnt <= '0;
    else if (ctl.busyClr)  busyCnt <= '0;
    else if (ctl.busyInc)  busyCnt <= busyCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            blkRemain <= '0;
    else if (ctl.ldCfg)   blkRemain <= cfgBlkCnt;
    else if (ctl.blkDec)  blkRemain <= blkRemain - 1'b1;
  end

  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldByte |-> (bitCnt == 4'd0));  // R4
  AST_NO_DATA_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldByte |-> (byteCnt != '0));  // R3
  AST_BLK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blkDec |-> (blkRemain != '0));  // R7

endmodule

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
  import blkwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       blkCntNz,
  input  logic       cfgAutoStop,
  input  logic       cardReady,
  input  logic       cmdDone,
  input  logic       cmdRespErr,
  input  logic       wrValid,
  input  logic       datIn,
  input  logic       bitEmpty,
  input  logic       shMsb,
  input  logic       crcMsb,
  input  logic       dataLast,
  input  logic       crcLast,
  input  logic       tokLast,
  input  logic       tokOk,
  input  logic       busyTo,
  input  logic       blkLast,
  output dpCtl_t     ctl,
  output logic       cmdReq,
  output logic [5:0] cmdIdx,
  output logic       wrReady,
  output logic       datOut,
  output logic       datOe,
  output logic       datStrobe,
  output logic       doneIrq,
  output logic       errDataCrc,
  output logic       errBusyTo,
  output logic       errStop
);

  seqState_t state, nextState;
  logic autoStopQ;
  logic accept, setCrcErr, setBusyErr, setStopErr, setDone;
  seqState_t finishState;

  assign finishState = autoStopQ ? ST_STOP_REQ : ST_DONE;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    cmdReq     = 1'b0;
    cmdIdx     = CMD_WRITE_MULTI;
    wrReady    = 1'b0;
    datOut     = 1'b1;
    datOe      = 1'b0;
    datStrobe  = 1'b0;
    accept     = 1'b0;
    setCrcErr  = 1'b0;
    setBusyErr = 1'b0;
    setStopErr = 1'b0;
    setDone    = 1'b0;
    unique case (state)
      ST_IDLE: if (start && blkCntNz) begin
        accept    = 1'b1;
        ctl.ldCfg = 1'b1;
        nextState = ST_WAIT_RDY;
      end
      ST_WAIT_RDY: if (cardReady) begin
        cmdReq    = 1'b1;
        nextState = ST_CMD_WAIT;
      end
      ST_CMD_WAIT: if (cmdDone) begin
        ctl.clrBlk = 1'b1;
        nextState  = ST_SND_START;
      end
      ST_SND_START: begin
        datOe     = 1'b1;
        datStrobe = 1'b1;
        datOut    = 1'b0;
        nextState = ST_SND_DATA;
      end
      ST_SND_DATA: begin
        datOe = 1'b1;
        if (bitEmpty) begin
          wrReady    = 1'b1;
          ctl.ldByte = wrValid;
        end else begin
          ctl.shData = 1'b1;
          datStrobe  = 1'b1;
          datOut     = shMsb;
          if (dataLast) nextState = ST_SND_CRC;
        end
      end
      ST_SND_CRC: begin
        datOe     = 1'b1;
        datStrobe = 1'b1;
        datOut    = crcMsb;
        ctl.shCrc = 1'b1;
        if (crcLast) nextState = ST_SND_END;
      end
      ST_SND_END: begin
        datOe      = 1'b1;
        datStrobe  = 1'b1;
        ctl.tokClr = 1'b1;
        nextState  = ST_TOKEN;
      end
      ST_TOKEN: if (!datIn) nextState = ST_TOK_BITS;
      ST_TOK_BITS: begin
        ctl.tokShift = 1'b1;
        if (tokLast) nextState = ST_TOK_END;
      end
      ST_TOK_END: begin
        ctl.busyClr = 1'b1;
        if (tokOk) nextState = ST_BUSY;
        else begin
          setCrcErr = 1'b1;
          nextState = finishState;
        end
      end
      ST_BUSY: begin
        if (datIn) begin
          ctl.blkDec = 1'b1;
          if (blkLast) nextState = finishState;
          else begin
            ctl.clrBlk = 1'b1;
            nextState  = ST_SND_START;
          end
        end else if (busyTo) begin
          setBusyErr = 1'b1;
          nextState  = finishState;
        end else ctl.busyInc = 1'b1;
      end
      ST_STOP_REQ: begin
        cmdReq    = 1'b1;
        cmdIdx    = CMD_STOP;
        nextState = ST_STOP_WAIT;
      end
      ST_STOP_WAIT: if (cmdDone) begin
        setStopErr = cmdRespErr;
        nextState  = ST_DONE;
      end
      ST_DONE: begin
        setDone   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      autoStopQ  <= 1'b0;
      doneIrq    <= 1'b0;
      errDataCrc <= 1'b0;
      errBusyTo  <= 1'b0;
      errStop    <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        autoStopQ  <= cfgAutoStop;
        doneIrq    <= 1'b0;
        errDataCrc <= 1'b0;
        errBusyTo  <= 1'b0;
        errStop    <= 1'b0;
      end
      if (setCrcErr)  errDataCrc <= 1'b1;
      if (setBusyErr) errBusyTo  <= 1'b1;
      if (setStopErr) errStop    <= 1'b1;
      if (setDone)    doneIrq    <= 1'b1;
    end
  end

  AST_WRITE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdIdx == CMD_WRITE_MULTI) |-> cardReady);  // R2
  AST_NO_SEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !datIn) |=> !datOe);  // R6
  AST_STOP_ONLY_IF_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdIdx == CMD_STOP) |-> autoStopQ);  // R8
  AST_END_AFTER_CRC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SND_END) |-> $past(state) == ST_SND_CRC);  // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !(start && blkCntNz)) |=> doneIrq);  // R10

endmodule

// File: rtl/blkwr_seq.sv
module blkwr_seq
  import blkwr_pkg::*;
#(
  parameter int SZ_W       = 10,
  parameter int CNT_W      = 16,
  parameter int BUSY_LIMIT = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SZ_W-1:0]  cfgBlkSize,
  input  logic [CNT_W-1:0] cfgBlkCnt,
  input  logic             cfgAutoStop,
  input  logic             cfgStreamMode,
  input  logic             cardReady,
  output logic             cmdReq,
  output logic [5:0]       cmdIdx,
  input  logic             cmdDone,
  input  logic             cmdRespErr,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             datOut,
  output logic             datOe,
  output logic             datStrobe,
  input  logic             datIn,
  output logic [CNT_W-1:0] blkRemain,
  output logic             doneIrq,
  output logic             errDataCrc,
  output logic             errBusyTo,
  output logic             errStop,
  output logic             bufWrRdyIrq
);

  dpCtl_t ctl;
  logic bitEmpty, shMsb, crcMsb, dataLast, crcLast, tokLast, tokOk, busyTo, blkLast;

  assign bufWrRdyIrq = wrReady && !cfgStreamMode;

  blkwr_ctrl ctrl_i (
    .clk, .rstN, .start,
    .blkCntNz(cfgBlkCnt != '0),
    .cfgAutoStop, .cardReady, .cmdDone, .cmdRespErr, .wrValid, .datIn,
    .bitEmpty, .shMsb, .crcMsb, .dataLast, .crcLast, .tokLast, .tokOk,
    .busyTo, .blkLast, .ctl, .cmdReq, .cmdIdx, .wrReady, .datOut, .datOe,
    .datStrobe, .doneIrq, .errDataCrc, .errBusyTo, .errStop
  );

  blkwr_dp #(.SZ_W(SZ_W), .CNT_W(CNT_W), .BUSY_LIMIT(BUSY_LIMIT)) dp_i (
    .clk, .rstN, .ctl, .cfgBlkSize, .cfgBlkCnt, .wrData, .datIn,
    .bitEmpty, .shMsb, .crcMsb, .dataLast, .crcLast, .tokLast, .tokOk,
    .busyTo, .blkLast, .blkRemain
  );

endmodule

// File: tb/blkwr_seq_tb_top.sv
module blkwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SZ_W = 10;
  localparam int CNT_W = 16;
  localparam int BUSY_LIMIT = 40;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [SZ_W-1:0] cfgBlkSize = '0;
  logic [CNT_W-1:0] cfgBlkCnt = '0;
  logic cfgAutoStop = 1'b0, cfgStreamMode = 1'b0, cardReady = 1'b1;
  logic cmdReq, cmdDone = 1'b0, cmdRespErr = 1'b0;
  logic [5:0] cmdIdx;
  logic [7:0] wrData = '0;
  logic wrValid = 1'b0, wrReady, datOut, datOe, datStrobe, datIn = 1'b1;
  logic [CNT_W-1:0] blkRemain;
  logic doneIrq, errDataCrc, errBusyTo, errStop, bufWrRdyIrq;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 0;

  // card and source model state
  int curSize = 1, bitIdx = 0, ebi = 0, srcIdx = 0, rc = -1, busyLen = 3;
  int frames = 0, dataBad = 0, crcBad = 0, fmtBad = 0, viol = 0, tokBadAt = 0;
  int cmdCnt = 0, firstCmd = -1, lastCmd = -1, cmdCd = 0, bufCnt = 0;
  bit gapMode = 0, hsPend = 0, stopErr = 0;
  logic [7:0] byteAcc = '0;
  logic [15:0] mcrc = '0, rxCrc = '0;
  logic [2:0] tokNow = 3'b010;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkwr_seq #(.SZ_W(SZ_W), .CNT_W(CNT_W), .BUSY_LIMIT(BUSY_LIMIT)) dut_i (
    .clk, .rstN, .start, .cfgBlkSize, .cfgBlkCnt, .cfgAutoStop, .cfgStreamMode,
    .cardReady, .cmdReq, .cmdIdx, .cmdDone, .cmdRespErr, .wrData, .wrValid,
    .wrReady, .datOut, .datOe, .datStrobe, .datIn, .blkRemain, .doneIrq,
    .errDataCrc, .errBusyTo, .errStop, .bufWrRdyIrq
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [15:0] crcStep(logic [15:0] c, logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  // models: payload source, card data line, command unit
  always @(negedge clk) begin
    cyc++;
    if (hsPend) srcIdx++;
    wrData  = pat(srcIdx);
    wrValid = !gapMode || (cyc % 4 != 0);
    hsPend  = wrValid && wrReady;
    if (bufWrRdyIrq) bufCnt++;

    if (rc >= 0) begin
      if (rc < 2) datIn = 1'b1;
      else if (rc == 2) datIn = 1'b0;
      else if (rc <= 5) datIn = tokNow[5 - rc];
      else if (rc == 6) datIn = 1'b1;
      else if (rc < 7 + busyLen) datIn = 1'b0;
      else begin datIn = 1'b1; rc = -2; end
      rc++;
      if (rc == 0) rc = -1;
    end

    if (datStrobe) begin
      if (rc >= 0) viol++;
      if (bitIdx == 0) begin
        if (datOut !== 1'b0) fmtBad++;
      end else if (bitIdx <= 8 * curSize) begin
        byteAcc = {byteAcc[6:0], datOut};
        mcrc = crcStep(mcrc, datOut);
        if (bitIdx % 8 == 0) begin
          if (byteAcc !== pat(ebi)) dataBad++;
          ebi++;
        end
      end else if (bitIdx <= 8 * curSize + 16) begin
        rxCrc = {rxCrc[14:0], datOut};
        if (bitIdx == 8 * curSize + 16 && rxCrc !== mcrc) crcBad++;
      end else begin
        if (datOut !== 1'b1) fmtBad++;
        frames++;
        tokNow = (frames == tokBadAt) ? 3'b101 : 3'b010;
        mcrc = '0;
        bitIdx = -1;
        rc = 0;
      end
      bitIdx++;
    end

    cmdDone = 1'b0;
    cmdRespErr = 1'b0;
    if (cmdCd > 0) begin
      cmdCd--;
      if (cmdCd == 0) begin
        cmdDone = 1'b1;
        cmdRespErr = (lastCmd == 12) && stopErr;
      end
    end
    if (cmdReq) begin
      cmdCnt++;
      if (firstCmd < 0) firstCmd = int'(cmdIdx);
      lastCmd = int'(cmdIdx);
      cmdCd = 3;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearModel();
    frames = 0; dataBad = 0; crcBad = 0; fmtBad = 0; viol = 0;
    cmdCnt = 0; firstCmd = -1; lastCmd = -1; bufCnt = 0;
  endtask

  task automatic startXfer(int size, int cnt, bit autoStop, bit stream, bit gaps,
                           int badAt, int busy, bit sErr);
    clearModel();
    curSize = size; gapMode = gaps; tokBadAt = badAt; busyLen = busy; stopErr = sErr;
    tokNow = (badAt == 1) ? 3'b101 : 3'b010;
    cfgBlkSize = SZ_W'(size); cfgBlkCnt = CNT_W'(cnt);
    cfgAutoStop = autoStop; cfgStreamMode = stream;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (!doneIrq && n < 20000) begin @(negedge clk); n++; end
    chk(req, int'(doneIrq), 1);
    repeat (150) @(negedge clk);
  endtask

  task automatic endChecks(string tag, int expFrames, int expCmds, int expLast,
                           int expCrc, int expBusy, int expStop, int expRemain);
    chk({tag, " R3 frames"}, frames, expFrames);
    chk({tag, " R3 crc"}, crcBad, 0);
    chk({tag, " R3 format"}, fmtBad, 0);
    chk({tag, " R4 data"}, dataBad, 0);
    chk({tag, " R6 no send while busy"}, viol, 0);
    chk({tag, " R2 first cmd"}, firstCmd, 25);
    chk({tag, " R8 cmd count"}, cmdCnt, expCmds);
    chk({tag, " R8 last cmd"}, lastCmd, expLast);
    chk({tag, " R5 errDataCrc"}, int'(errDataCrc), expCrc);
    chk({tag, " R6 errBusyTo"}, int'(errBusyTo), expBusy);
    chk({tag, " R9 errStop"}, int'(errStop), expStop);
    chk({tag, " R7 blkRemain"}, int'(blkRemain), expRemain);
  endtask

  task automatic testReset();
    chk("R1 cmdReq", int'(cmdReq), 0);
    chk("R1 datOe", int'(datOe), 0);
    chk("R1 datStrobe", int'(datStrobe), 0);
    chk("R1 wrReady", int'(wrReady), 0);
    chk("R1 doneIrq", int'(doneIrq), 0);
    chk("R1 errors", int'({errDataCrc, errBusyTo, errStop}), 0);
  endtask

  task automatic testSingle();
    startXfer(4, 1, 1, 0, 0, 0, 3, 0);
    waitDone("R10 single done");
    endChecks("single", 1, 2, 12, 0, 0, 0, 0);
    chk("R11 bufWrRdy seen in buffer mode", int'(bufCnt > 0), 1);
  endtask

  task automatic testMultiGaps();
    startXfer(3, 3, 1, 1, 1, 0, 9, 0);
    waitDone("R10 multi done");
    endChecks("multi gaps", 3, 2, 12, 0, 0, 0, 0);
    chk("R11 bufWrRdy masked in stream mode", bufCnt, 0);
  endtask

  task automatic testNoAutoStop();
    startXfer(2, 2, 0, 1, 0, 0, 2, 0);
    waitDone("R10 no-autostop done");
    endChecks("no autostop R8", 2, 1, 25, 0, 0, 0, 0);
  endtask

  task automatic testWaitReady();
    cardReady = 1'b0;
    startXfer(2, 1, 1, 1, 0, 0, 2, 0);
    repeat (20) @(negedge clk);
    chk("R2 no cmd before ready", cmdCnt, 0);
    chk("R2 line idle before ready", int'(datOe), 0);
    chk("R10 doneIrq cleared on start", int'(doneIrq), 0);
    cardReady = 1'b1;
    waitDone("R2 done after ready");
    endChecks("wait ready", 1, 2, 12, 0, 0, 0, 0);
  endtask

  task automatic testBadToken();
    startXfer(2, 3, 1, 1, 0, 2, 2, 0);
    waitDone("R5 bad token done");
    endChecks("bad token", 2, 2, 12, 1, 0, 0, 2);
  endtask

  task automatic testBusyTimeout();
    startXfer(2, 2, 1, 1, 0, 0, 100, 0);
    waitDone("R6 timeout done");
    endChecks("busy timeout", 1, 2, 12, 0, 1, 0, 2);
  endtask

  task automatic testStopErr();
    startXfer(1, 1, 1, 1, 0, 0, 1, 1);
    waitDone("R9 stop err done");
    endChecks("stop err", 1, 2, 12, 0, 0, 1, 0);
  endtask

  task automatic testZeroCount();
    startXfer(2, 0, 1, 0, 0, 0, 1, 0);
    repeat (30) @(negedge clk);
    chk("R2 zero count no cmd", cmdCnt, 0);
    chk("R2 zero count no data", frames, 0);
    chk("R2 zero count wrReady", int'(wrReady), 0);
    chk("R10 zero count keeps doneIrq", int'(doneIrq), 1);
    chk("R10 zero count keeps errStop", int'(errStop), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testSingle();
    testMultiGaps();
    testNoAutoStop();
    testWaitReady();
    testBadToken();
    testBusyTimeout();
    testStopErr();
    testZeroCount();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule